// File: doc/BRIEF.md
# Seconds Counter with Alarm Interrupt

This block is a memory-mapped seconds counter. A 32-bit count advances by one on each single-cycle `tick` pulse, provided the run bit in the control register is set. Software reads the count, loads a new start value through a separate load register, and programs a compare value. When a tick moves the count onto the compare value, a sticky alarm status bit is set. That bit passes through a mask and drives one interrupt line.

The register bus is a single-cycle strobe interface. A write with `bus_sel` and `bus_wr` high takes effect at the next rising clock edge. A read with `bus_sel` high and `bus_wr` low returns data combinationally in the same cycle. The oscillator, the prescaler that makes `tick`, and any calendar conversion sit outside the block.

Top module: `rtc_alarm_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads zero, the counter is stopped, and `irq` is low.
- R2: Byte offsets decode as follows. 0x00 returns the current count. 0x04 is the compare value. 0x08 returns the last loaded value. 0x0C holds the run bit at bit 26, and its other bits read 0. 0x10 is the interrupt mask in bits [1:0]. 0x14 is raw status. 0x18 is masked status. 0x1C (clear) reads 0, and so does any unmapped offset.
- R3: Writing 0x08 sets the count to the written value at that clock edge. A load takes priority over a tick in the same cycle.
- R4: The count increases by one at each tick while the run bit is 1. It holds while the run bit is 0. It wraps from 0xFFFFFFFF to 0.
- R5: Raw status bit 0 (alarm) is set at the tick edge where the count becomes equal to the compare value. A load that makes the count equal to the compare value does not set it. Once set, the bit stays set until it is cleared.
- R6: Masked status equals raw status AND mask. `irq` is high exactly when any masked status bit is 1.
- R7: Writing 1 to a bit of 0x1C clears that raw status bit. Writing 0 leaves the bit unchanged.
- R8: A clear of bit 0 in the same cycle as a new alarm event leaves bit 0 set.
- R9: Writes to 0x00, 0x14 and 0x18 change no register.
- R10: Bit 1 (periodic) can be written and read back in the mask. Its raw status reads 0, because the block has no periodic source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq | output | 1 | Interrupt, OR of the masked status bits |

## Verification
Every register write, every load and every tick takes effect at the rising edge of the cycle in which it is presented. The count, status bits and `irq` therefore show the result one edge after the stimulus. Reads are combinational, with no latency. The bench drives each operation on a falling edge and lets exactly one rising edge pass. It then samples on the following low phase and compares against a bench-side model that was advanced by that same single edge. The same-cycle cases are driven as one combined operation, so their ordering is fixed by the stimulus and does not depend on scheduling: load with tick, and clear with alarm.

// File: rtl/rtc_pkg.sv
// Shared constants for the seconds counter: register byte offsets and
// status bit positions. Assumes a 32-bit data path.
package rtc_pkg;
    localparam int unsigned OFS_COUNT  = 32'h00;
    localparam int unsigned OFS_MATCH  = 32'h04;
    localparam int unsigned OFS_LOAD   = 32'h08;
    localparam int unsigned OFS_CTRL   = 32'h0C;
    localparam int unsigned OFS_MASK   = 32'h10;
    localparam int unsigned OFS_RAW    = 32'h14;
    localparam int unsigned OFS_MSK_ST = 32'h18;
    localparam int unsigned OFS_CLEAR  = 32'h1C;
    localparam int unsigned BIT_ALARM  = 0;
    localparam int unsigned BIT_PERIOD = 1;
endpackage

// File: rtl/rtc_sec_counter.sv
// Seconds counter: loads on request (priority) or steps by one.
// Assumes step is already qualified by the run bit.
module rtc_sec_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] cnt_inc
);
    assign cnt_inc = cnt + DATA_W'(1);

    // Count register: reset, load, or increment with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load_en) cnt <= load_val;
        else if (step)    cnt <= cnt_inc;
    end
endmodule

// File: rtl/rtc_match_unit.sv
// Alarm event detector: flags the step at which the counter lands on
// the compare value. Loads never produce an event.
module rtc_match_unit #(
    parameter int DATA_W = 32
) (
    input  logic              step,
    input  logic              load_en,
    input  logic [DATA_W-1:0] cnt_inc,
    input  logic [DATA_W-1:0] match_val,
    output logic              hit
);
    // Event when the value about to be stored equals the compare value.
    always_comb hit = step && !load_en && (cnt_inc == match_val);
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Interrupt bookkeeping: sticky raw bits with write-1-to-clear, a mask
// register, masked status and a single OR'ed line. A set wins over a
// clear in the same cycle.
module rtc_irq_ctrl #(
    parameter int IRQ_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_vec,
    input  logic             clr_wr,
    input  logic [IRQ_W-1:0] clr_vec,
    input  logic             mask_wr,
    input  logic [IRQ_W-1:0] mask_val,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    for (genvar i = 0; i < IRQ_W; i++) begin : g_raw
        // One sticky status bit: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                      raw[i] <= 1'b0;
            else if (set_vec[i])             raw[i] <= 1'b1;
            else if (clr_wr && clr_vec[i])   raw[i] <= 1'b0;
        end
    end

    // Mask register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_val;
    end

    always_comb begin
        masked = raw & mask;
        irq    = |masked;
    end
endmodule

// File: rtl/rtc_alarm_top.sv
// Top of the seconds counter: register decode, compare/load/control
// registers and read mux. Writes land at the clock edge; reads are
// combinational. Assumes word-aligned byte offsets.
module rtc_alarm_top
    import rtc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    parameter int IRQ_W   = 2,
    parameter int RUN_BIT = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(OFS_MATCH);
    localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MSK_ST = ADDR_W'(OFS_MSK_ST);

    logic              wr_hit, ld_wr, match_wr, ctrl_wr, mask_wr, clr_wr;
    logic [DATA_W-1:0] cnt_q, cnt_inc, match_q, load_q;
    logic              run_q, step, alarm_hit;
    logic [IRQ_W-1:0]  set_vec, raw_q, mask_q, masked;

    // Write strobes per register.
    always_comb begin
        wr_hit   = bus_sel && bus_wr;
        ld_wr    = wr_hit && (bus_addr == A_LOAD);
        match_wr = wr_hit && (bus_addr == A_MATCH);
        ctrl_wr  = wr_hit && (bus_addr == A_CTRL);
        mask_wr  = wr_hit && (bus_addr == A_MASK);
        clr_wr   = wr_hit && (bus_addr == ADDR_W'(OFS_CLEAR));
        step     = tick && run_q;
    end

    // Compare, load-shadow and run-bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            load_q  <= '0;
            run_q   <= 1'b0;
        end else begin
            if (match_wr) match_q <= bus_wdata;
            if (ld_wr)    load_q  <= bus_wdata;
            if (ctrl_wr)  run_q   <= bus_wdata[RUN_BIT];
        end
    end

    rtc_sec_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_en(ld_wr), .load_val(bus_wdata),
        .step(step), .cnt(cnt_q), .cnt_inc(cnt_inc)
    );

    rtc_match_unit #(.DATA_W(DATA_W)) u_match (
        .step(step), .load_en(ld_wr), .cnt_inc(cnt_inc),
        .match_val(match_q), .hit(alarm_hit)
    );

    // Only the alarm has a source; the periodic bit never sets.
    always_comb begin
        set_vec            = '0;
        set_vec[BIT_ALARM] = alarm_hit;
    end

    rtc_irq_ctrl #(.IRQ_W(IRQ_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_wr(clr_wr),
        .clr_vec(bus_wdata[IRQ_W-1:0]), .mask_wr(mask_wr),
        .mask_val(bus_wdata[IRQ_W-1:0]), .raw(raw_q), .mask(mask_q),
        .masked(masked), .irq(irq)
    );

    // Read mux: combinational, zero for clear and unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                A_COUNT:  bus_rdata = cnt_q;
                A_MATCH:  bus_rdata = match_q;
                A_LOAD:   bus_rdata = load_q;
                A_CTRL:   bus_rdata[RUN_BIT] = run_q;
                A_MASK:   bus_rdata = DATA_W'(mask_q);
                A_RAW:    bus_rdata = DATA_W'(raw_q);
                A_MSK_ST: bus_rdata = DATA_W'(masked);
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_alarm_chk.sv
// Property checker for rtc_alarm_top, attached by bind below. Observes
// bus strobes and internal state; drives nothing.
module rtc_alarm_chk #(
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              ld_wr,
    input logic              clr_wr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] match,
    input logic              run,
    input logic [IRQ_W-1:0]  raw,
    input logic [IRQ_W-1:0]  mask,
    input logic              irq
);
    logic ev, clr0;
    always_comb begin
        ev   = tick && run && !ld_wr && ((cnt + DATA_W'(1)) == match);
        clr0 = clr_wr && wdata[0];
    end

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> cnt == $past(wdata));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !ld_wr) |=> cnt == $past(cnt) + DATA_W'(1));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && run) && !ld_wr) |=> $stable(cnt));
    p_alarm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> raw[0]);
    p_alarm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[0] && !clr0) |=> raw[0]);
    p_no_irq_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !ev) |=> !raw[0]);
    p_clear_race_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && ev) |=> raw[0]);
endmodule

bind rtc_alarm_top rtc_alarm_chk #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_wr(ld_wr), .clr_wr(clr_wr),
    .wdata(bus_wdata), .cnt(cnt_q), .match(match_q), .run(run_q),
    .raw(raw_q), .mask(mask_q), .irq(irq)
);

// File: tb/tb_rtc_alarm_top.sv
module tb_rtc_alarm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    // Bench-side model state.
    logic [31:0] m_cnt, m_match, m_load;
    logic        m_run;
    logic [1:0]  m_mask, m_raw;

    rtc_alarm_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00: return m_cnt;
            5'h04: return m_match;
            5'h08: return m_load;
            5'h0C: return {5'b0, m_run, 26'b0};
            5'h10: return {30'b0, m_mask};
            5'h14: return {30'b0, m_raw};
            5'h18: return {30'b0, m_raw & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    // Advance model by one edge with the given stimulus.
    task automatic model_step(input logic t, input logic w, input logic [4:0] a, input logic [31:0] d);
        logic ld, ev;
        ld = w && a == 5'h08;
        ev = t && m_run && !ld && (m_cnt + 32'd1 == m_match);
        if (ld) begin m_cnt = d; m_load = d; end
        else if (t && m_run) m_cnt = m_cnt + 32'd1;
        if (ev) m_raw[0] = 1'b1;
        else if (w && a == 5'h1C && d[0]) m_raw[0] = 1'b0;
        if (w && a == 5'h1C && d[1]) m_raw[1] = 1'b0;
        if (w && a == 5'h04) m_match = d;
        if (w && a == 5'h0C) m_run = d[26];
        if (w && a == 5'h10) m_mask = d[1:0];
    endtask

    // One bus/tick cycle: drive at falling edge, one rising edge passes.
    task automatic cyc(input logic t, input logic w, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        tick = t; bus_sel = w; bus_wr = w; bus_addr = a; bus_wdata = d;
        model_step(t, w, a, d);
        @(negedge clk);
        tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic tk();
        cyc(1'b1, 1'b0, 5'h00, 32'h0);
    endtask

    // Combinational read in the low phase; consumes no edge.
    task automatic rd_check(input string req, input logic [4:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp_read(a));
        bus_sel = 1'b0;
        #0.5;
    endtask

    task automatic irq_check(input string req);
        check(req, {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        m_cnt = 0; m_match = 0; m_load = 0; m_run = 0; m_mask = 0; m_raw = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 32; a += 4) rd_check("R1", 5'(a));
        irq_check("R1");

        // R4 hold while stopped
        tk();
        rd_check("R4 stopped", 5'h00);

        // R2/R3 load and readback; R4 counting
        wr(5'h0C, 32'h0400_0000);
        rd_check("R2 ctrl", 5'h0C);
        wr(5'h08, 32'h0000_1000);
        rd_check("R3 load", 5'h00);
        rd_check("R2 loadreg", 5'h08);
        tk(); tk();
        rd_check("R4 step", 5'h00);

        // R3 load beats tick
        cyc(1'b1, 1'b1, 5'h08, 32'h0000_0050);
        rd_check("R3 priority", 5'h00);

        // R9 read-only writes ignored
        wr(5'h00, 32'hDEAD_BEEF);
        wr(5'h14, 32'h3);
        wr(5'h18, 32'h3);
        rd_check("R9 count", 5'h00);
        rd_check("R9 raw", 5'h14);
        rd_check("R2 clear reads 0", 5'h1C);

        // R5 load onto match sets nothing
        wr(5'h04, 32'h0000_0060);
        wr(5'h08, 32'h0000_0060);
        rd_check("R5 load-no-alarm", 5'h14);

        // R5 alarm on tick, R6 masked/irq
        wr(5'h08, 32'h0000_005F);
        tk();
        rd_check("R5 alarm", 5'h14);
        rd_check("R6 masked off", 5'h18);
        irq_check("R6 irq off");
        wr(5'h10, 32'h1);
        rd_check("R6 masked on", 5'h18);
        irq_check("R6 irq on");
        tk();
        rd_check("R5 sticky", 5'h14);

        // R7 write 0 no effect, write 1 clears
        wr(5'h1C, 32'h0);
        rd_check("R7 zero", 5'h14);
        wr(5'h1C, 32'h1);
        rd_check("R7 clear", 5'h14);
        irq_check("R7 irq");

        // R8 clear together with new event
        wr(5'h08, 32'h0000_005F);
        cyc(1'b1, 1'b1, 5'h1C, 32'h1);
        rd_check("R8 race", 5'h14);
        irq_check("R8 irq");

        // R4 wrap, alarm at zero
        wr(5'h1C, 32'h1);
        wr(5'h04, 32'h0);
        wr(5'h08, 32'hFFFF_FFFF);
        tk();
        rd_check("R4 wrap", 5'h00);
        rd_check("R5 wrap alarm", 5'h14);

        // R10 periodic mask bit
        wr(5'h10, 32'h2);
        rd_check("R10 mask", 5'h10);
        rd_check("R10 raw", 5'h14);
        irq_check("R10 irq");

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1, 2, 3: tk();
                4: wr(5'h08, m_match - 32'($urandom_range(0, 3)));
                5: wr(5'h04, m_cnt + 32'($urandom_range(1, 3)));
                6: wr(5'h10, 32'($urandom_range(0, 3)));
                7: wr(5'h1C, 32'($urandom_range(0, 3)));
                8: wr(5'h0C, ($urandom_range(0, 3) != 0) ? 32'h0400_0000 : 32'h0);
                default: cyc(1'b1, 1'b1, 5'h1C, 32'h1);
            endcase
            rd_check("R2 R4 R5 rnd", 5'(4 * $urandom_range(0, 7)));
            irq_check("R6 rnd");
        end

        summary();
    end
endmodule